// File: doc/BRIEF.md
# Alternating Stop-and-Go Keystream Generator

This block produces a keystream one bit per enabled cycle from three shift registers. A control register steps on every enabled cycle, and its low bit picks which of the two data registers, left or right, steps with it. The other data register holds its state. The low bits of the left and right registers are combined into the keystream bit. The combiner is either a plain exclusive-or or a one-bit adder that keeps its carry from one output to the next.

A compile-time mode sets which registers are linear feedback shift registers and which are feedback-with-carry shift registers, and which combiner is used. Software loads the three seeds with a one-cycle load pulse. The load also clears every carry in the block. After that, each cycle with the enable high gives one keystream bit, marked by a valid flag in the next cycle. This stream has no back-pressure: the consumer must take each bit in the cycle its valid flag is high.

Top module: `stop_go_keygen`

## Requirements
- R1: While reset is low and in the first cycle after it, `ks_bit` and `ks_valid` are 0.
- R2: A cycle with `load` high copies `seed_ctrl`, `seed_left` and `seed_right` into the three registers and clears every register carry and the combiner carry. `load` takes priority over `en`, and `ks_valid` is 0 in the following cycle.
- R3: A cycle with `en` low and `load` low changes no register or carry. In the next cycle `ks_valid` is 0 and `ks_bit` keeps its value.
- R4: In each enabled cycle the control register steps. If its bit 0 was 1 before the step, the left register steps and the right register holds. If it was 0, the right register steps and the left register holds.
- R5: A linear register of length L steps by shifting right one place. The new bit L-1 is the XOR of bits 0, 3 and L/2 (integer division).
- R6: A carry register of length L forms s = bit0 + bit3 + bit(L/2) + carry. It shifts right, puts s mod 2 into bit L-1, and sets carry to s div 2. The carry never exceeds 2.
- R7: With the XOR combiner, the output bit is left bit 0 XOR right bit 0, taken before that cycle's steps.
- R8: With the adding combiner, the output bit is (left bit 0 + right bit 0 + c) mod 2 and c becomes the same sum div 2. Both bits are taken before that cycle's steps, and c is updated on every enabled cycle.
- R9: MODE 0 makes all three registers carry registers with the XOR combiner. MODE 1 makes the control register a carry register and left and right linear, with the adding combiner. MODE 2 makes the control register linear and left and right carry registers, with the XOR combiner.
- R10: Every enabled cycle, including the first one after a load, gives one output: `ks_valid` is 1 in the following cycle and `ks_bit` holds that cycle's bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Seed load strobe |
| seed_ctrl | input | LEN_CTRL | Seed for the control register |
| seed_left | input | LEN_LEFT | Seed for the left data register |
| seed_right | input | LEN_RIGHT | Seed for the right data register |
| en | input | 1 | Step the generator and emit one bit |
| ks_bit | output | 1 | Keystream bit |
| ks_valid | output | 1 | High for one cycle per emitted bit |

## Verification
The bench runs all three modes side by side from the same seeds. It compares more than a thousand bits per mode against an arithmetic model. A selector with its polarity swapped, or a data register that steps on every cycle, makes the streams diverge within a few bits. So does a carry that is dropped or kept as only one bit. Idle cycles are spread through the run to catch a design that advances, or flags output, while the enable is low. A reload with the enable high checks that a design which does not clear its carries, or which lets the enable win over the load, produces a wrong stream after the reload.

// File: rtl/sg_pkg.sv
package sg_pkg;

  typedef enum logic [1:0] {
    SG_ALL_CARRY      = 2'd0,
    SG_CARRY_CTRL_ADD = 2'd1,
    SG_LINEAR_CTRL    = 2'd2
  } sg_mode_e;

  localparam int SG_TAP_LO   = 3;
  localparam int SG_CARRY_W  = 2;

  function automatic bit ctrl_is_carry(sg_mode_e m);
    return m != SG_LINEAR_CTRL;
  endfunction

  function automatic bit data_is_carry(sg_mode_e m);
    return m != SG_CARRY_CTRL_ADD;
  endfunction

  function automatic bit combine_adds(sg_mode_e m);
    return m == SG_CARRY_CTRL_ADD;
  endfunction

endpackage

// File: rtl/sg_shiftreg.sv
module sg_shiftreg #(
  parameter int LEN      = 17,
  parameter bit IS_CARRY = 1'b0,
  parameter int CARRY_W  = sg_pkg::SG_CARRY_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [LEN-1:0] seed,
  input  logic           step,
  output logic           out_bit
);
  localparam int TAP_LO  = sg_pkg::SG_TAP_LO;
  localparam int TAP_MID = LEN / 2;
  localparam int SUM_W   = CARRY_W + 1;

  logic [LEN-1:0]     state;
  logic [CARRY_W-1:0] carry;
  logic [SUM_W-1:0]   tap_sum;
  logic               next_bit;
  logic [CARRY_W-1:0] next_carry;

  // Parity of the tap sum equals the XOR of the taps when the carry is zero,
  // so one adder serves both register kinds.
  always_comb begin
    tap_sum = SUM_W'(state[0]) + SUM_W'(state[TAP_LO]) + SUM_W'(state[TAP_MID])
            + SUM_W'(carry);
    next_bit = tap_sum[0];
  end

  generate
    if (IS_CARRY) begin : g_carry
      assign next_carry = tap_sum[SUM_W-1:1];
    end else begin : g_linear
      assign next_carry = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= {{(LEN-1){1'b0}}, 1'b1};
      carry <= '0;
    end else if (load) begin
      state <= seed;
      carry <= '0;
    end else if (step) begin
      state <= {next_bit, state[LEN-1:1]};
      carry <= next_carry;
    end
  end

  assign out_bit = state[0];

  p_hold_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(state) && $stable(carry));

  p_load_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (state == $past(seed)) && (carry == '0));

  p_carry_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    carry <= CARRY_W'(2));

endmodule

// File: rtl/sg_combiner.sv
module sg_combiner #(
  parameter bit USE_ADD = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic en,
  input  logic a,
  input  logic b,
  output logic ks_bit,
  output logic ks_valid
);
  logic       c;
  logic [1:0] sum;
  logic       bit_next;
  logic       c_next;

  always_comb sum = {1'b0, a} + {1'b0, b} + {1'b0, c};

  generate
    if (USE_ADD) begin : g_add
      assign bit_next = sum[0];
      assign c_next   = sum[1];
    end else begin : g_xor
      assign bit_next = a ^ b;
      assign c_next   = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ks_bit   <= 1'b0;
      ks_valid <= 1'b0;
      c        <= 1'b0;
    end else if (load) begin
      ks_valid <= 1'b0;
      c        <= 1'b0;
    end else if (en) begin
      ks_bit   <= bit_next;
      ks_valid <= 1'b1;
      c        <= c_next;
    end else begin
      ks_valid <= 1'b0;
    end
  end

  p_valid_after_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load) |=> ks_valid);

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> !ks_valid && $stable(ks_bit) && $stable(c));

  p_load_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !ks_valid && !c);

endmodule

// File: rtl/stop_go_keygen.sv
module stop_go_keygen #(
  parameter sg_pkg::sg_mode_e MODE = sg_pkg::SG_ALL_CARRY,
  parameter int LEN_CTRL  = 17,
  parameter int LEN_LEFT  = 19,
  parameter int LEN_RIGHT = 23
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [LEN_CTRL-1:0]  seed_ctrl,
  input  logic [LEN_LEFT-1:0]  seed_left,
  input  logic [LEN_RIGHT-1:0] seed_right,
  input  logic                 en,
  output logic                 ks_bit,
  output logic                 ks_valid
);
  localparam bit CTRL_CARRY = sg_pkg::ctrl_is_carry(MODE);
  localparam bit DATA_CARRY = sg_pkg::data_is_carry(MODE);
  localparam bit ADD_COMB   = sg_pkg::combine_adds(MODE);

  logic advance;
  logic sel;
  logic left_bit;
  logic right_bit;

  assign advance = en && !load;

  sg_shiftreg #(.LEN(LEN_CTRL), .IS_CARRY(CTRL_CARRY)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .load(load), .seed(seed_ctrl),
    .step(advance), .out_bit(sel)
  );

  sg_shiftreg #(.LEN(LEN_LEFT), .IS_CARRY(DATA_CARRY)) u_left (
    .clk(clk), .rst_n(rst_n), .load(load), .seed(seed_left),
    .step(advance && sel), .out_bit(left_bit)
  );

  sg_shiftreg #(.LEN(LEN_RIGHT), .IS_CARRY(DATA_CARRY)) u_right (
    .clk(clk), .rst_n(rst_n), .load(load), .seed(seed_right),
    .step(advance && !sel), .out_bit(right_bit)
  );

  sg_combiner #(.USE_ADD(ADD_COMB)) u_comb (
    .clk(clk), .rst_n(rst_n), .load(load), .en(en),
    .a(left_bit), .b(right_bit), .ks_bit(ks_bit), .ks_valid(ks_valid)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> !ks_valid && !ks_bit);

endmodule

// File: tb/stop_go_keygen_tb.sv
`timescale 1ns/1ps
module stop_go_keygen_tb;
  localparam int LC = 17, LL = 19, LR = 23;
  localparam int LEN_OF [3] = '{LC, LL, LR};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic en = 1'b0;
  logic [LC-1:0] seed_c = '0;
  logic [LL-1:0] seed_l = '0;
  logic [LR-1:0] seed_r = '0;
  logic ks_bit [3];
  logic ks_valid [3];

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  for (genvar m = 0; m < 3; m++) begin : g_mode
    stop_go_keygen #(.MODE(sg_pkg::sg_mode_e'(m))) u_dut (
      .clk(clk), .rst_n(rst_n), .load(load),
      .seed_ctrl(seed_c), .seed_left(seed_l), .seed_right(seed_r),
      .en(en), .ks_bit(ks_bit[m]), .ks_valid(ks_valid[m])
    );
  end

  // model state: [mode][register 0=ctrl 1=left 2=right]
  logic [31:0] ms [3][3];
  int          mc [3][3];
  int          acc [3];
  int          expb [3];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step_reg(input bit carry_kind, input int len,
                          inout logic [31:0] s, inout int c);
    int sum;
    int nb;
    sum = int'(s[0]) + int'(s[3]) + int'(s[len/2]);
    if (carry_kind) begin
      sum = sum + c;          // R6
      nb  = sum % 2;
      c   = sum / 2;
    end else begin
      nb  = sum % 2;          // R5: parity of three taps
      c   = 0;
    end
    s = (s >> 1) | (32'(nb) << (len - 1));
  endtask

  task automatic model_load(input logic [31:0] a, input logic [31:0] b, input logic [31:0] d);
    for (int m = 0; m < 3; m++) begin
      ms[m][0] = a & ((32'd1 << LC) - 1);
      ms[m][1] = b & ((32'd1 << LL) - 1);
      ms[m][2] = d & ((32'd1 << LR) - 1);
      for (int r = 0; r < 3; r++) mc[m][r] = 0;
      acc[m] = 0;
    end
  endtask

  // R9 mode mapping, R4 selection, R7/R8 combining
  task automatic model_step(input int m);
    bit cc, dc, ad;
    int s;
    int sel;
    cc = (m != 2);
    dc = (m != 1);
    ad = (m == 1);
    if (ad) begin
      s = int'(ms[m][1][0]) + int'(ms[m][2][0]) + acc[m];
      expb[m] = s % 2;
      acc[m]  = s / 2;
    end else begin
      expb[m] = int'(ms[m][1][0] ^ ms[m][2][0]);
    end
    sel = int'(ms[m][0][0]);
    step_reg(cc, LEN_OF[0], ms[m][0], mc[m][0]);
    if (sel == 1) step_reg(dc, LEN_OF[1], ms[m][1], mc[m][1]);
    else          step_reg(dc, LEN_OF[2], ms[m][2], mc[m][2]);
  endtask

  initial begin
    #(4 * 5000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int prev [3];
    repeat (3) @(negedge clk);
    for (int m = 0; m < 3; m++) begin
      chk(ks_bit[m] == 1'b0, "R1 ks_bit in reset", int'(ks_bit[m]), 0);
      chk(ks_valid[m] == 1'b0, "R1 ks_valid in reset", int'(ks_valid[m]), 0);
    end
    rst_n = 1'b1;
    @(posedge clk); #1;
    for (int m = 0; m < 3; m++)
      chk(ks_valid[m] == 1'b0, "R1 ks_valid after reset", int'(ks_valid[m]), 0);

    @(negedge clk);
    seed_c = 17'h1_2C5B; seed_l = 19'h5_A3E1; seed_r = 23'h3B_19D7;
    load = 1'b1; en = 1'b0;
    model_load(32'h1_2C5B, 32'h5_A3E1, 32'h3B_19D7);
    @(posedge clk); #1;
    for (int m = 0; m < 3; m++)
      chk(ks_valid[m] == 1'b0, "R2 no output on load", int'(ks_valid[m]), 0);

    for (int i = 0; i < 1250; i++) begin
      bit ld, e;
      @(negedge clk);
      ld = (i == 620);
      e  = (i % 7 != 3) || ld;
      for (int m = 0; m < 3; m++) prev[m] = int'(ks_bit[m]);
      load = ld; en = e;
      if (ld) begin
        // R2: load with en high; carries cleared, enable ignored
        seed_c = 17'h0_9F3A; seed_l = 19'h2_71C8; seed_r = 23'h61_0E4B;
        model_load(32'h0_9F3A, 32'h2_71C8, 32'h61_0E4B);
      end else if (e) begin
        for (int m = 0; m < 3; m++) model_step(m);
      end
      @(posedge clk); #1;
      for (int m = 0; m < 3; m++) begin
        if (ld) begin
          chk(ks_valid[m] == 1'b0, "R2 load wins over en", int'(ks_valid[m]), 0);
        end else if (e) begin
          chk(ks_valid[m] == 1'b1, "R10 valid per enabled cycle", int'(ks_valid[m]), 1);
          chk(int'(ks_bit[m]) == expb[m], m == 1 ? "R8 add combiner stream (R4 R5 R6 R9)"
                                                 : "R7 xor combiner stream (R4 R5 R6 R9)",
              int'(ks_bit[m]), expb[m]);
        end else begin
          chk(ks_valid[m] == 1'b0, "R3 idle no valid", int'(ks_valid[m]), 0);
          chk(int'(ks_bit[m]) == prev[m], "R3 idle holds bit", int'(ks_bit[m]), prev[m]);
        end
      end
    end
    load = 1'b0; en = 1'b0;
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule